// File: doc/BRIEF.md
# Atomic Read-Compare-Write Sequencer

This block runs the two-pass atomic operations of a shared cache bank. These are compare-and-swap, unconditional swap, and test-and-set-byte. A request always arrives as two beats. The head beat carries the operation, the address, the I/O-space flag and the compare data. The tail beat carries the swap data.

The sequencer then reads the addressed word through a simple one-cycle-latency memory port and returns the old value as a load-style response. In that same cycle it writes the new word when the operation calls for it. In the following cycle it sends a store-style acknowledgement. Both responses carry the atomic flag. The acknowledgement carries an invalidate-all-copies strobe when, and only when, memory was written.

While one operation is in flight, the request port is closed, so no other access can slip in between the read and the write. An atomic request aimed at I/O space, or one that uses the reserved operation code, gets a single reject response and never touches memory.

Top module: `atomic_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `reqReady` is 1 and `rspValid`, `memRdEn`, `memWrEn` and `invAll` are 0.
- R2: A beat is taken on a clock edge where `reqValid` and `reqReady` are both 1. The head beat supplies `reqOp`, `reqIo`, `reqAddr` and the compare data. The tail beat supplies only `reqData` (the swap data); its `reqOp`, `reqIo` and `reqAddr` have no effect. `reqReady` stays 0 from the cycle after the tail beat until the response of that operation has completed.
- R3: For a legal operation, the first response has `rspType` = 01 (load return), `rspAtomic` = 1, and `rspData` equal to the addressed word as it was before the operation.
- R4: Compare-and-swap (`reqOp` = 00) writes the swap data when the old word equals the compare data. Otherwise it leaves the word unchanged.
- R5: Swap (`reqOp` = 01) always writes the swap data.
- R6: Test-and-set-byte (`reqOp` = 10) always writes 0xFF into byte lane k = `reqAddr[2:0]` (bits 8k+7..8k) and keeps every other byte of the word. Swap data has no effect on it.
- R7: The cycle right after the load return carries `rspType` = 10 (store acknowledgement), `rspAtomic` = 1 and `rspData` = 0.
- R8: `invAll` is 1 in the acknowledgement cycle exactly when the operation wrote memory, and 0 in every other cycle.
- R9: When the head beat has `reqIo` = 1 or `reqOp` = 11, exactly one response follows, with `rspType` = 11 and `rspAtomic` = 0. No memory read or write takes place.
- R10: `memWrEn` is 1 for at most one cycle per operation. That cycle is the load-return cycle, and the write goes to word address `reqAddr[ADDR_W-1:3]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request beat present |
| reqReady | output | 1 | Sequencer can take a beat |
| reqOp | input | 2 | Operation: 00 CAS, 01 swap, 10 test-and-set-byte, 11 reserved |
| reqIo | input | 1 | Head beat targets I/O space |
| reqAddr | input | ADDR_W | Byte address (head beat) |
| reqData | input | DATA_W | Compare data (head) or swap data (tail) |
| memRdEn | output | 1 | Memory read strobe |
| memWrEn | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W-3 | Word address |
| memWrData | output | DATA_W | Word to write |
| memRdData | input | DATA_W | Read word, valid the cycle after `memRdEn` |
| rspValid | output | 1 | Response beat present |
| rspType | output | 2 | 01 load return, 10 acknowledgement, 11 reject |
| rspAtomic | output | 1 | Atomic flag |
| rspData | output | DATA_W | Old word on a load return, else 0 |
| invAll | output | 1 | Invalidate all first-level copies |

## Verification
Two things share the load-return cycle: the memory write of the new word and the return of the old word. A write-back that came one cycle early or late would therefore either return the new value or fall outside the response window. The bench samples every cycle of each operation. It requires that any `memWrEn` coincides with a type-01 response that carries the pre-operation word, and that `invAll` on the following acknowledgement agrees with whether that write happened. The stimulus mixes compare-and-swap with matching and mismatching compare data, swaps, test-and-set on every byte lane, a test-and-set on a byte that is already 0xFF, and rejected requests. Tail beats carry scrambled operation, address and space fields throughout.

// File: rtl/atomic_seq_pkg.sv
package atomic_seq_pkg;

  typedef enum logic [1:0] {
    OP_CAS  = 2'b00,
    OP_SWAP = 2'b01,
    OP_TAS  = 2'b10,
    OP_RSVD = 2'b11
  } atomOp_e;

  typedef enum logic [1:0] {
    RSP_NONE = 2'b00,
    RSP_LOAD = 2'b01,
    RSP_ACK  = 2'b10,
    RSP_REJ  = 2'b11
  } rspKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeHead;
    logic takeTail;
    logic takeOld;
    logic wrEnable;
    logic showOld;
  } dpCtl_t;

endpackage

// File: rtl/atomic_seq_ctrl.sv
module atomic_seq_ctrl
  import atomic_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     illegal,
  input  logic     doWrite,
  output logic     reqReady,
  output dpCtl_t   ctl,
  output logic     memRdEn,
  output logic     memWrEn,
  output logic     rspValid,
  output rspKind_e rspType,
  output logic     rspAtomic,
  output logic     invAll
);

  typedef enum logic [2:0] {
    S_HEAD, S_TAIL, S_READ, S_LATCH, S_RET, S_ACK, S_REJ
  } state_e;

  state_e state, nextState;
  logic   beatTaken;

  assign beatTaken = reqValid && reqReady;

  always_comb begin
    nextState = state;
    unique case (state)
      S_HEAD:  if (beatTaken) nextState = S_TAIL;
      S_TAIL:  if (beatTaken) nextState = illegal ? S_REJ : S_READ;
      S_READ:  nextState = S_LATCH;
      S_LATCH: nextState = S_RET;
      S_RET:   nextState = S_ACK;
      S_ACK:   nextState = S_HEAD;
      S_REJ:   nextState = S_HEAD;
      default: nextState = S_HEAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_HEAD;
    else       state <= nextState;
  end

  always_comb begin
    reqReady     = (state == S_HEAD) || (state == S_TAIL);
    ctl.takeHead = (state == S_HEAD) && beatTaken;
    ctl.takeTail = (state == S_TAIL) && beatTaken;
    ctl.takeOld  = (state == S_LATCH);
    ctl.wrEnable = (state == S_RET) && doWrite;
    ctl.showOld  = (state == S_RET);
    memRdEn      = (state == S_READ);
    memWrEn      = ctl.wrEnable;
    rspValid     = (state == S_RET) || (state == S_ACK) || (state == S_REJ);
    rspAtomic    = (state == S_RET) || (state == S_ACK);
    invAll       = (state == S_ACK) && doWrite;
    unique case (state)
      S_RET:   rspType = RSP_LOAD;
      S_ACK:   rspType = RSP_ACK;
      S_REJ:   rspType = RSP_REJ;
      default: rspType = RSP_NONE;
    endcase
  end

  // R3
  load_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspType == RSP_LOAD) |-> $past(memRdEn, 2));
  // R7
  ack_follows_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspType == RSP_LOAD) |=> (rspValid && rspType == RSP_ACK && rspAtomic));
  // R8
  inv_on_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    invAll |-> (rspValid && rspType == RSP_ACK && $past(memWrEn)));
  // R10
  write_in_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (rspValid && rspType == RSP_LOAD));
  // R9
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspType == RSP_REJ) |-> (!memWrEn && !rspAtomic && !$past(memRdEn)));
  // R2
  closed_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !reqReady);

endmodule

// File: rtl/atomic_seq_dp.sv
module atomic_seq_dp
  import atomic_seq_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 12
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpCtl_t                        ctl,
  input  logic [1:0]                    reqOp,
  input  logic                          reqIo,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [DATA_W-1:0]             reqData,
  input  logic [DATA_W-1:0]             memRdData,
  output logic                          illegal,
  output logic                          doWrite,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] memAddr,
  output logic [DATA_W-1:0]             memWrData,
  output logic [DATA_W-1:0]             rspData
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  atomOp_e           opQ;
  logic              ioQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] cmpQ, swpQ, oldQ, newQ;
  logic              writeQ;
  logic [LANE_W-1:0] lane;
  logic [DATA_W-1:0] tasWord, newWord;
  logic              cmpHit, wantWrite;

  assign lane = addrQ[LANE_W-1:0];

  // byte-lane merge for test-and-set
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign tasWord[g*8 +: 8] = (lane == LANE_W'(g)) ? 8'hFF : memRdData[g*8 +: 8];
  end

  always_comb begin
    cmpHit = (memRdData == cmpQ);
    unique case (opQ)
      OP_CAS:  begin wantWrite = cmpHit; newWord = swpQ;      end
      OP_SWAP: begin wantWrite = 1'b1;   newWord = swpQ;      end
      OP_TAS:  begin wantWrite = 1'b1;   newWord = tasWord;   end
      default: begin wantWrite = 1'b0;   newWord = memRdData; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ    <= OP_CAS;
      ioQ    <= 1'b0;
      addrQ  <= '0;
      cmpQ   <= '0;
      swpQ   <= '0;
      oldQ   <= '0;
      newQ   <= '0;
      writeQ <= 1'b0;
    end else begin
      if (ctl.takeHead) begin
        opQ   <= atomOp_e'(reqOp);
        ioQ   <= reqIo;
        addrQ <= reqAddr;
        cmpQ  <= reqData;
      end
      if (ctl.takeTail) swpQ <= reqData;
      if (ctl.takeOld) begin
        oldQ   <= memRdData;
        newQ   <= newWord;
        writeQ <= wantWrite;
      end
    end
  end

  assign illegal   = ioQ || (opQ == OP_RSVD);
  assign doWrite   = writeQ;
  assign memAddr   = addrQ[ADDR_W-1:LANE_W];
  assign memWrData = newQ;
  assign rspData   = ctl.showOld ? oldQ : '0;

  // R4
  cas_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrEnable && opQ == OP_CAS) |-> (oldQ == cmpQ && memWrData == swpQ));
  // R6
  tas_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrEnable && opQ == OP_TAS) |-> (memWrData[{lane, 3'b000} +: 8] == 8'hFF));
  // R9
  no_write_illegal_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrEnable |-> !illegal);

endmodule

// File: rtl/atomic_seq.sv
module atomic_seq
  import atomic_seq_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [1:0]              reqOp,
  input  logic                    reqIo,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [DATA_W-1:0]       reqData,
  output logic                    memRdEn,
  output logic                    memWrEn,
  output logic [ADDR_W-4:0]       memAddr,
  output logic [DATA_W-1:0]       memWrData,
  input  logic [DATA_W-1:0]       memRdData,
  output logic                    rspValid,
  output logic [1:0]              rspType,
  output logic                    rspAtomic,
  output logic [DATA_W-1:0]       rspData,
  output logic                    invAll
);

  dpCtl_t   ctl;
  logic     illegal, doWrite;
  rspKind_e rspKind;

  atomic_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .illegal   (illegal),
    .doWrite   (doWrite),
    .reqReady  (reqReady),
    .ctl       (ctl),
    .memRdEn   (memRdEn),
    .memWrEn   (memWrEn),
    .rspValid  (rspValid),
    .rspType   (rspKind),
    .rspAtomic (rspAtomic),
    .invAll    (invAll)
  );

  atomic_seq_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqOp     (reqOp),
    .reqIo     (reqIo),
    .reqAddr   (reqAddr),
    .reqData   (reqData),
    .memRdData (memRdData),
    .illegal   (illegal),
    .doWrite   (doWrite),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .rspData   (rspData)
  );

  assign rspType = rspKind;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rstN) |-> (reqReady && !rspValid && !memRdEn && !memWrEn && !invAll));

endmodule

// File: tb/atomic_seq_tb_top.sv
module atomic_seq_tb_top;

  localparam int DW = 64;
  localparam int AW = 12;
  localparam int WORDS = 1 << (AW - 3);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [1:0] reqOp = '0;
  logic reqIo = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic memRdEn, memWrEn;
  logic [AW-4:0] memAddr;
  logic [DW-1:0] memWrData;
  logic [DW-1:0] memRdData = '0;
  logic rspValid, rspAtomic, invAll;
  logic [1:0] rspType;
  logic [DW-1:0] rspData;

  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] shadow [WORDS];

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  atomic_seq #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqIo(reqIo), .reqAddr(reqAddr), .reqData(reqData),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .memAddr(memAddr),
    .memWrData(memWrData), .memRdData(memRdData), .rspValid(rspValid),
    .rspType(rspType), .rspAtomic(rspAtomic), .rspData(rspData), .invAll(invAll)
  );

  // memory model, one-cycle read latency
  always @(posedge clk) begin
    if (memRdEn) memRdData <= mem[memAddr];
    if (memWrEn) mem[memAddr] <= memWrData;
  end

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expNew(input logic [1:0] op, input logic [DW-1:0] old,
      input logic [DW-1:0] cmpD, input logic [DW-1:0] swpD, input logic [2:0] ln);
    logic [DW-1:0] w;
    w = old;
    case (op)
      2'b00: if (old == cmpD) w = swpD;
      2'b01: w = swpD;
      2'b10: w[{ln, 3'b000} +: 8] = 8'hFF;
      default: w = old;
    endcase
    return w;
  endfunction

  task automatic runOp(input logic [1:0] op, input logic io, input logic [AW-1:0] addr,
                       input logic [DW-1:0] cmpD, input logic [DW-1:0] swpD);
    logic [AW-4:0] word;
    logic [DW-1:0] old, nw;
    bit legal, wantWr, gotLoad, gotAck, gotRej, ackNext, readyLeak, wrBad;
    int wrCnt, rdCnt, loadCyc, ackCyc;
    logic [DW-1:0] loadData, ackData;
    logic loadAtom, ackAtom, ackInv, rejAtom, invStray;
    string tag;
    word = addr[AW-1:3];
    old = shadow[word];
    legal = !io && op != 2'b11;
    nw = expNew(op, old, cmpD, swpD, addr[2:0]);
    wantWr = legal && (nw != old || op != 2'b00 || old == cmpD);
    tag = (op == 2'b00) ? "R4" : (op == 2'b01) ? "R5" : "R6";
    // head beat
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqIo = io; reqAddr = addr; reqData = cmpD;
    @(negedge clk);
    check(reqReady == 1'b1, "R2 tail ready", {63'd0, reqReady}, 64'd1);
    // tail beat with scrambled side fields
    reqOp = ~op; reqIo = ~io; reqAddr = ~addr; reqData = swpD;
    @(negedge clk);
    reqValid = 1'b0; reqData = '1;
    gotLoad = 0; gotAck = 0; gotRej = 0; readyLeak = 0; wrBad = 0; invStray = 0;
    wrCnt = 0; rdCnt = 0; loadCyc = -1; ackCyc = -1;
    loadData = '0; ackData = '0; loadAtom = 0; ackAtom = 0; ackInv = 0; rejAtom = 0;
    for (int k = 0; k < 16; k++) begin
      if (reqReady) readyLeak = 1;
      if (memRdEn) rdCnt++;
      if (memWrEn) begin
        wrCnt++;
        if (!(rspValid && rspType == 2'b01) || memAddr != word) wrBad = 1;
      end
      if (invAll && !(rspValid && rspType == 2'b10)) invStray = 1;
      if (rspValid) begin
        if (rspType == 2'b01) begin
          gotLoad = 1; loadCyc = k; loadData = rspData; loadAtom = rspAtomic;
        end else if (rspType == 2'b10) begin
          gotAck = 1; ackCyc = k; ackData = rspData; ackAtom = rspAtomic; ackInv = invAll;
        end else if (rspType == 2'b11) begin
          gotRej = 1; rejAtom = rspAtomic;
        end
      end
      if (gotAck || gotRej) break;
      @(negedge clk);
    end
    check(!readyLeak, "R2 port closed during operation", {63'd0, readyLeak}, 64'd0);
    check(!invStray, "R8 invAll outside ack", {63'd0, invStray}, 64'd0);
    if (legal) begin
      check(gotLoad && loadAtom, "R3 load return type/atomic", {62'd0, gotLoad, loadAtom}, 64'd3);
      check(loadData == old, "R3 old word", loadData, old);
      ackNext = gotAck && ackCyc == loadCyc + 1;
      check(ackNext && ackAtom && ackData == '0, "R7 ack follows load", ackData, 64'd0);
      check(ackInv == wantWr, "R8 invAll on ack", {63'd0, ackInv}, {63'd0, wantWr});
      check(wrCnt == int'(wantWr) && !wrBad, "R10 write count/cycle",
            DW'(wrCnt), DW'(wantWr));
      check(mem[word] == nw, tag, mem[word], nw);
      if (wantWr) shadow[word] = nw;
    end else begin
      check(gotRej && !rejAtom && !gotLoad, "R9 reject response", {62'd0, gotRej, rejAtom}, 64'd2);
      check(wrCnt == 0 && rdCnt == 0, "R9 no memory access", DW'(wrCnt + rdCnt), 64'd0);
      check(mem[word] == old, "R9 memory unchanged", mem[word], old);
    end
    @(negedge clk);
    check(reqReady == 1'b1, "R2 reopen", {63'd0, reqReady}, 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] r;
    logic [1:0] op;
    logic [AW-1:0] a;
    void'($urandom(32'd20240611));
    for (int i = 0; i < WORDS; i++) begin
      r = {$urandom(), $urandom()};
      mem[i] = r;
      shadow[i] = r;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check(reqReady && !rspValid && !memRdEn && !memWrEn && !invAll, "R1 reset state",
          {59'd0, reqReady, rspValid, memRdEn, memWrEn, invAll}, 64'h10);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !rspValid && !memRdEn && !memWrEn && !invAll, "R1 after reset",
          {59'd0, reqReady, rspValid, memRdEn, memWrEn, invAll}, 64'h10);

    // directed corners
    runOp(2'b00, 1'b0, 12'h040, shadow[8], 64'h1111_2222_3333_4444);  // R4 match
    runOp(2'b00, 1'b0, 12'h040, 64'h0, 64'hDEAD_BEEF_0000_0001);       // R4 miss
    runOp(2'b01, 1'b0, 12'h088, 64'h0, 64'hA5A5_5A5A_A5A5_5A5A);       // R5
    for (int ln = 0; ln < 8; ln++)
      runOp(2'b10, 1'b0, 12'h100 + AW'(ln), 64'h0, 64'h0);             // R6 all lanes
    runOp(2'b10, 1'b0, 12'h103, 64'h0, 64'h1234);                      // R6 byte already FF
    runOp(2'b00, 1'b1, 12'h200, shadow[64], 64'h5);                    // R9 io
    runOp(2'b11, 1'b0, 12'h208, 64'h0, 64'h6);                         // R9 reserved op

    // constrained random
    for (int i = 0; i < 400; i++) begin
      op = 2'($urandom_range(0, 2));
      if ($urandom_range(0, 15) == 0) op = 2'b11;
      a = AW'($urandom());
      r = ($urandom_range(0, 1) == 1) ? shadow[a[AW-1:3]] : {$urandom(), $urandom()};
      runOp(op, $urandom_range(0, 9) == 0, a, r, {$urandom(), $urandom()});
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule